// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block gives the column address for each clock of an SDRAM burst. A one-cycle start pulse captures a 10-bit starting column, a burst-length code and an order select. From the next clock on, the block presents one column per clock with a valid flag. A last-beat flag marks the final beat of a fixed-length burst.

Fixed bursts of 2, 4 or 8 beats stay inside the aligned block of that size that holds the starting column. A full-page burst walks the whole row and wraps around. A stop input ends any burst. A new start restarts the sequence on the next clock, so a fresh column can be issued on every clock. Command decoding, the data path and latency alignment belong to neighbouring logic.

Top module: `sdram_burst_col_gen`

## Requirements
- R1: While reset is asserted and after it is released with no start, valid_o and last_o are 0.
- R2: On the clock after start_i is sampled high, valid_o is 1 and col_o equals the col_i sampled with the start, for every length code and order.
- R3: Length codes are bl_i = 3'b000 (1 beat), 3'b001 (2), 3'b010 (4) and 3'b011 (8). With ilv_i = 0, beat i presents the start column with its low log2(BL) bits replaced by (start + i) mod BL, and the upper bits unchanged.
- R4: With ilv_i = 1 and a fixed length, beat i presents the start column with its low log2(BL) bits XORed with i.
- R5: For a fixed length, last_o is 1 exactly on beat BL-1. On the next clock valid_o is 0 unless a start was sampled on the last beat.
- R6: With length code 3'b000, the burst is a single beat at the start column, and last_o is 1 on that beat.
- R7: Any bl_i with bit 2 set selects full page. The order is sequential whatever ilv_i is, each beat is the previous column plus one modulo 1024, last_o stays 0, and the burst runs until stopped.
- R8: A stop_i sampled high during a burst without start_i makes valid_o 0 on the next clock. A stop_i sampled while idle has no effect.
- R9: A start_i sampled during a burst restarts at the new column on the next clock, even when stop_i is high in the same cycle. Starts on consecutive clocks each give their own column.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Load the starting column and begin a burst |
| stop_i | input | 1 | End the running burst |
| col_i | input | 10 | Starting column |
| bl_i | input | 3 | Burst length code (see R3, R7) |
| ilv_i | input | 1 | 1 selects interleaved order, 0 sequential |
| valid_o | output | 1 | A beat is presented on col_o |
| col_o | output | 10 | Column for the current beat |
| last_o | output | 1 | Current beat is the last of a fixed burst |

## Verification
Every starting column is swept under each fixed length and both orders. This separates the sequential add-and-wrap from the XOR order, and shows any carry leaking into the upper bits at block edges. A full-page run starting near the top of the row shows the wrap from 1023 to 0, that the interleave select is ignored, and that last_o stays low. Stops sent while idle and during a burst, starts colliding with a stop, and starts on consecutive clocks separate restart priority from termination.

// File: rtl/burst_pkg.sv
`timescale 1ns/1ps
package burst_pkg;
  localparam int unsigned BL_SEL_W = 3;
  localparam int unsigned BL_FULL_BIT = 2;

  typedef struct packed {
    logic full;
    logic ilv;
  } burst_cfg_t;
endpackage

// File: rtl/burst_ctrl.sv
`timescale 1ns/1ps
module burst_ctrl
  import burst_pkg::*;
#(
  parameter int unsigned COL_W = 10
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic                stop_i,
  input  logic [COL_W-1:0]    col_i,
  input  logic [BL_SEL_W-1:0] bl_i,
  input  logic                ilv_i,
  output logic                active_o,
  output logic                last_o,
  output burst_cfg_t          cfg_o,
  output logic [COL_W-1:0]    base_o,
  output logic [COL_W-1:0]    beat_o,
  output logic [COL_W-1:0]    mask_o
);
  localparam logic [COL_W-1:0] ONE = COL_W'(1);

  logic             active_q;
  logic [COL_W-1:0] beat_q, base_q, mask_q;
  burst_cfg_t       cfg_q;
  logic [COL_W-1:0] mask_d;
  logic             last;

  // full page spans the row; fixed length BL gives mask BL-1
  always_comb begin
    if (bl_i[BL_FULL_BIT]) mask_d = '1;
    else                   mask_d = (ONE << bl_i[1:0]) - ONE;
  end

  assign last = active_q && !cfg_q.full && (beat_q == mask_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      beat_q   <= '0;
      base_q   <= '0;
      mask_q   <= '0;
      cfg_q    <= '0;
    end else if (start_i) begin
      active_q  <= 1'b1;
      beat_q    <= '0;
      base_q    <= col_i;
      mask_q    <= mask_d;
      cfg_q.full <= bl_i[BL_FULL_BIT];
      cfg_q.ilv  <= ilv_i && !bl_i[BL_FULL_BIT];
    end else if (active_q) begin
      if (stop_i || last) active_q <= 1'b0;
      else                beat_q   <= beat_q + ONE;
    end
  end

  assign active_o = active_q;
  assign last_o   = last;
  assign cfg_o    = cfg_q;
  assign base_o   = base_q;
  assign beat_o   = beat_q;
  assign mask_o   = mask_q;

  AST_BL1_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !bl_i[BL_FULL_BIT] && (bl_i[1:0] == 2'd0) |=> last_o); // R6
  AST_LAST_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o && !start_i |=> !active_o); // R5
  AST_STOP_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_o && stop_i && !start_i |=> !active_o); // R8
  AST_BEAT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q && !cfg_q.full |-> beat_q <= mask_q); // R5
endmodule

// File: rtl/burst_addr.sv
`timescale 1ns/1ps
module burst_addr
  import burst_pkg::*;
#(
  parameter int unsigned COL_W = 10
) (
  input  burst_cfg_t       cfg_i,
  input  logic [COL_W-1:0] base_i,
  input  logic [COL_W-1:0] beat_i,
  input  logic [COL_W-1:0] mask_i,
  output logic [COL_W-1:0] col_o
);
  logic [COL_W-1:0] sum;

  assign sum = base_i + beat_i;

  // bits under the mask follow the order, bits above stay at the start column
  for (genvar b = 0; b < COL_W; b++) begin : g_bit
    assign col_o[b] = !mask_i[b] ? base_i[b]
                    : cfg_i.ilv  ? (base_i[b] ^ beat_i[b])
                    :              sum[b];
  end
endmodule

// File: rtl/sdram_burst_col_gen.sv
`timescale 1ns/1ps
module sdram_burst_col_gen
  import burst_pkg::*;
#(
  parameter int unsigned COL_W = 10
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic                stop_i,
  input  logic [COL_W-1:0]    col_i,
  input  logic [BL_SEL_W-1:0] bl_i,
  input  logic                ilv_i,
  output logic                valid_o,
  output logic [COL_W-1:0]    col_o,
  output logic                last_o
);
  burst_cfg_t       cfg;
  logic [COL_W-1:0] base, beat, mask;

  burst_ctrl #(.COL_W(COL_W)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .stop_i   (stop_i),
    .col_i    (col_i),
    .bl_i     (bl_i),
    .ilv_i    (ilv_i),
    .active_o (valid_o),
    .last_o   (last_o),
    .cfg_o    (cfg),
    .base_o   (base),
    .beat_o   (beat),
    .mask_o   (mask)
  );

  burst_addr #(.COL_W(COL_W)) u_addr (
    .cfg_i  (cfg),
    .base_i (base),
    .beat_i (beat),
    .mask_i (mask),
    .col_o  (col_o)
  );

  AST_START_COL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> valid_o && (col_o == $past(col_i))); // R2
  AST_UPPER_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !last_o && !start_i && !stop_i
    |=> valid_o && ((col_o & ~mask) == ($past(col_o) & ~$past(mask)))); // R3
  AST_FP_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && cfg.full && !start_i && !stop_i
    |=> valid_o && !last_o && (col_o == $past(col_o) + COL_W'(1))); // R7
  AST_RESET_IDLE: assert property (@(posedge clk_i)
    !rst_ni |-> !valid_o && !last_o); // R1
endmodule

// File: tb/sim_sdram_burst_col_gen.sv
`timescale 1ns/1ps
module sim_sdram_burst_col_gen;
  localparam int COL_W = 10;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0, stop_i = 1'b0, ilv_i = 1'b0;
  logic [COL_W-1:0] col_i = '0;
  logic [2:0] bl_i = '0;
  logic valid_o, last_o;
  logic [COL_W-1:0] col_o;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  sdram_burst_col_gen #(.COL_W(COL_W)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .stop_i(stop_i),
    .col_i(col_i), .bl_i(bl_i), .ilv_i(ilv_i),
    .valid_o(valid_o), .col_o(col_o), .last_o(last_o)
  );

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_col(input int start, input int bl, input bit ilv, input int i);
    int m = bl - 1;
    if (ilv) return (start & ~m) | ((start ^ i) & m);
    return (start & ~m) | ((start + i) & m);
  endfunction

  // start at one negedge, check each beat at the following negedges
  task automatic run_burst(input int start, input int code, input bit ilv);
    int bl = 1 << code;
    @(negedge clk);
    start_i = 1'b1; col_i = COL_W'(start); bl_i = 3'(code); ilv_i = ilv;
    for (int i = 0; i < bl; i++) begin
      @(negedge clk);
      start_i = 1'b0;
      if (i == 0) check(valid_o && col_o == COL_W'(start), "R2 first beat", int'(col_o), start);
      if (ilv) check(valid_o && int'(col_o) == exp_col(start, bl, 1, i), "R4 interleaved column",
                     int'(col_o), exp_col(start, bl, 1, i));
      else     check(valid_o && int'(col_o) == exp_col(start, bl, 0, i), "R3 sequential column",
                     int'(col_o), exp_col(start, bl, 0, i));
      if (bl == 1) check(last_o == 1'b1, "R6 single beat last", int'(last_o), 1);
      else check(last_o == (i == bl - 1), "R5 last flag", int'(last_o), int'(i == bl - 1));
    end
    @(negedge clk);
    check(valid_o == 1'b0, "R5 idle after last", int'(valid_o), 0);
  endtask

  initial begin
    #1_800_000;
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(valid_o == 1'b0 && last_o == 1'b0, "R1 in reset", int'(valid_o), 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    check(valid_o == 1'b0 && last_o == 1'b0, "R1 after reset", int'(valid_o), 0);

    // sweep every start column, fixed length and order
    for (int code = 0; code < 4; code++)
      for (int ilv = 0; ilv < 2; ilv++)
        for (int c = 0; c < 1024; c++)
          run_burst(c, code, ilv[0]);

    // R7: full page from 1020 with interleave requested, wraps through 0
    @(negedge clk);
    start_i = 1'b1; col_i = 10'd1020; bl_i = 3'b100; ilv_i = 1'b1;
    for (int i = 0; i < 1030; i++) begin
      @(negedge clk);
      start_i = 1'b0;
      check(valid_o && int'(col_o) == (1020 + i) % 1024 && !last_o, "R7 full page column",
            int'(col_o), (1020 + i) % 1024);
    end
    stop_i = 1'b1;
    @(negedge clk);
    stop_i = 1'b0;
    check(valid_o == 1'b0, "R8 stop ends full page", int'(valid_o), 0);

    // R7: other full-page codes
    for (int code = 5; code < 8; code++) begin
      @(negedge clk);
      start_i = 1'b1; col_i = 10'd7; bl_i = 3'(code); ilv_i = 1'b1;
      for (int i = 0; i < 12; i++) begin
        @(negedge clk);
        start_i = 1'b0;
        check(valid_o && int'(col_o) == 7 + i && !last_o, "R7 full page code", int'(col_o), 7 + i);
      end
      stop_i = 1'b1;
      @(negedge clk);
      stop_i = 1'b0;
      check(valid_o == 1'b0, "R8 stop full page code", int'(valid_o), 0);
    end

    // R8: stop while idle has no effect, then a burst still runs in full
    stop_i = 1'b1;
    repeat (3) begin
      @(negedge clk);
      check(valid_o == 1'b0, "R8 idle stop", int'(valid_o), 0);
    end
    stop_i = 1'b0;
    run_burst(13, 3, 1'b0);

    // R8: stop in the middle of an 8-beat burst
    @(negedge clk);
    start_i = 1'b1; col_i = 10'd5; bl_i = 3'b011; ilv_i = 1'b0;
    @(negedge clk); start_i = 1'b0;
    @(negedge clk);
    check(valid_o && col_o == 10'd6, "R8 beat before stop", int'(col_o), 6);
    stop_i = 1'b1;
    @(negedge clk);
    stop_i = 1'b0;
    check(valid_o == 1'b0, "R8 stop mid burst", int'(valid_o), 0);

    // R9: start together with stop mid burst restarts
    @(negedge clk);
    start_i = 1'b1; col_i = 10'd100; bl_i = 3'b010; ilv_i = 1'b0;
    @(negedge clk);
    start_i = 1'b1; stop_i = 1'b1; col_i = 10'd302; bl_i = 3'b010; ilv_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0; stop_i = 1'b0;
    check(valid_o && col_o == 10'd302 && !last_o, "R9 start beats stop", int'(col_o), 302);
    @(negedge clk);
    check(valid_o && col_o == 10'd303, "R9 restarted order", int'(col_o), 303);

    // R9: start on the last beat keeps going
    @(negedge clk);
    start_i = 1'b1; col_i = 10'd40; bl_i = 3'b001; ilv_i = 1'b0;
    @(negedge clk);
    start_i = 1'b0;
    @(negedge clk);
    check(last_o == 1'b1 && col_o == 10'd41, "R5 last of two", int'(col_o), 41);
    start_i = 1'b1; col_i = 10'd77; bl_i = 3'b000;
    @(negedge clk);
    start_i = 1'b0;
    check(valid_o && col_o == 10'd77 && last_o, "R9 start on last beat", int'(col_o), 77);

    // R9: back-to-back starts, one new column per clock
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (k > 0) check(valid_o && int'(col_o) == (k * 37 + 11) % 1024 - 37 + ((k * 37 + 11) % 1024 < 37 ? 1024 : 0)
                       && !last_o, "R9 back to back", int'(col_o), ((k - 1) * 37 + 11) % 1024);
      start_i = 1'b1; col_i = COL_W'((k * 37 + 11) % 1024); bl_i = 3'b011; ilv_i = k[0];
    end
    @(negedge clk);
    start_i = 1'b0;
    check(valid_o && int'(col_o) == (39 * 37 + 11) % 1024, "R9 final back to back",
          int'(col_o), (39 * 37 + 11) % 1024);

    // R1: reset mid burst clears outputs
    @(negedge clk);
    rst_ni = 1'b0;
    @(negedge clk);
    check(valid_o == 1'b0 && last_o == 1'b0, "R1 reset mid burst", int'(valid_o), 0);
    rst_ni = 1'b1;

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule